// File: doc/BRIEF.md
# Time-Slot Command/Indicate Channel Controller

This block handles short status and command codes exchanged over sixteen time-multiplexed channels. A slot strobe and a channel number tell it which channel owns the current cycle. In that cycle the block sends the channel's transmit code and takes in the channel's received code. Both codes are either 4 or 6 bits wide, and one configuration input sets that width for every channel.

To transmit, a host places a code in a staging register. It then writes a command that names the target channel. The channel repeats that code in each of its slots. A saturating counter records how many times the code has gone out, and the host can read it. On receive, the block stores each channel's latest code. It accepts a code only when two consecutive slots of the same channel carry the same value and that value differs from the last accepted one. Each accepted event goes into a small queue that holds the channel number and the code. An interrupt stays high while the queue holds anything. When the controller is disabled, slots carry the received data straight to the output and no protocol state changes.

Top module: `ci_tdm_ctrl`

## Requirements
- R1: After synchronous reset, `tx_out`, `irq` and `host_rdata` are zero. Every channel's transmit code is all ones, with its send count at "none".
- R2: Writing the command register (address 1) with bit 7 = 0 loads the staging register's code into channel `host_wdata[3:0]`. Every later enabled slot of that channel drives that code on `tx_out` one cycle after the slot cycle.
- R3: Reading the staging register (address 0) returns the code as written in bits 5:0. Bits 7:6 hold the send count of the last commanded channel: 00 = not yet sent, 01 = sent once, 10 = sent twice or more. The count saturates at 10, and a new transmit command resets it to 00.
- R4: With `cfg_wide` = 0, bits 5:4 of the transmitted code are forced to zero. Received codes are also cut to their low 4 bits before they are compared or stored.
- R5: A receive event is raised only when two consecutive valid slots of the same channel carry equal codes that differ from that channel's last accepted code. Slots of other channels in between do not break the pair. A single copy raises no event, and neither does a repeat of the accepted code.
- R6: `irq` is high exactly while the event queue is non-empty. Reading address 2 returns `{1, 000, channel}` for the oldest event and removes it. Reading address 3 returns `{00, code}` of the oldest event and leaves it in the queue. Reading address 2 while the queue is empty returns 0.
- R7: Up to `EVQ_DEPTH` events (default 4) are kept in arrival order. An event that arrives while the queue is full is dropped.
- R8: Writing the command register with bit 7 = 1 looks up channel `src[3:0]`. Address 1 then reads `{0, twice, code}`. Here `code` is the channel's latest received code, and `twice` = 1 if it equalled the copy before it.
- R9: With `cfg_enable` = 0, a valid slot drives the full 6-bit `rx_in` onto `tx_out` one cycle later. No event is raised, the send count does not change, and the receive memory is left untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | 1 = protocol active, 0 = plain pass-through |
| cfg_wide | input | 1 | 1 = 6-bit codes, 0 = 4-bit codes |
| slot_vld | input | 1 | Current cycle is a channel slot |
| slot_ch | input | 4 | Channel owning the slot |
| rx_in | input | 6 | Code received in the slot |
| tx_out | output | 6 | Code transmitted for the last slot (registered) |
| host_we | input | 1 | Host register write strobe |
| host_re | input | 1 | Host register read strobe |
| host_addr | input | 2 | Register select: 0 staging, 1 command/lookup, 2 status, 3 aux |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after `host_re` |
| irq | output | 1 | Receive event pending |

## Verification
The bench interleaves slots of other channels between the two matching copies. A filter that demanded truly back-to-back cycles would then miss the event. It also repeats an already accepted code, where a filter without the "differs from accepted" rule would raise a second interrupt. It drives the send count past two to catch a counter that wraps into an illegal code instead of saturating. It overfills the event queue to expose a design that overwrites the oldest entry rather than dropping the newest. Finally, it feeds the disabled controller a code pair that the enabled one would accept, so any protocol state leaking through pass-through mode would show up as an interrupt or as a changed lookup result.

// File: rtl/ci_pkg.sv
package ci_pkg;
  localparam int unsigned PW     = 6;   // widest code
  localparam int unsigned HOST_W = 8;   // host data width
  localparam logic [1:0] A_SRC  = 2'd0;
  localparam logic [1:0] A_CMD  = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;
  localparam logic [1:0] A_AUX  = 2'd3;
  localparam logic [1:0] CNT_NONE  = 2'd0;
  localparam logic [1:0] CNT_MULTI = 2'd2;
endpackage

// File: rtl/ci_tx_bank.sv
module ci_tx_bank
  import ci_pkg::*;
#(
  parameter int unsigned N_CH = 16,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PW-1:0]   mask,
  input  logic            slot_vld,
  input  logic [CH_W-1:0] slot_ch,
  input  logic [PW-1:0]   rx_in,
  input  logic            cmd_go,
  input  logic [CH_W-1:0] cmd_ch,
  input  logic [PW-1:0]   cmd_prim,
  input  logic [CH_W-1:0] sel_ch,
  output logic [1:0]      sel_cnt,
  output logic [PW-1:0]   tx_out
);
  logic [PW-1:0] prim_q [N_CH];
  logic [1:0]    cnt_q  [N_CH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) begin
        prim_q[i] <= '1;
        cnt_q[i]  <= CNT_NONE;
      end
      tx_out <= '0;
    end else begin
      if (slot_vld) begin
        if (en) begin
          tx_out <= prim_q[slot_ch] & mask;
          if (cnt_q[slot_ch] != CNT_MULTI)
            cnt_q[slot_ch] <= cnt_q[slot_ch] + 2'd1;
        end else begin
          tx_out <= rx_in;
        end
      end
      // a host command overrides a same-cycle count update
      if (cmd_go) begin
        prim_q[cmd_ch] <= cmd_prim;
        cnt_q[cmd_ch]  <= CNT_NONE;
      end
    end
  end

  assign sel_cnt = cnt_q[sel_ch];
endmodule

// File: rtl/ci_rx_filter.sv
module ci_rx_filter
  import ci_pkg::*;
#(
  parameter int unsigned N_CH = 16,
  localparam int unsigned CH_W = $clog2(N_CH)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [PW-1:0]   mask,
  input  logic            slot_vld,
  input  logic [CH_W-1:0] slot_ch,
  input  logic [PW-1:0]   rx_in,
  input  logic [CH_W-1:0] look_ch,
  output logic [PW-1:0]   look_prim,
  output logic            look_twice,
  output logic            acc_vld,
  output logic [CH_W-1:0] acc_ch,
  output logic [PW-1:0]   acc_prim
);
  logic [PW-1:0]   last_q [N_CH];   // latest copy seen
  logic [PW-1:0]   held_q [N_CH];   // last accepted code
  logic [N_CH-1:0] twice_q;
  logic [PW-1:0]   x;
  logic            hit;

  always_comb begin
    x        = rx_in & mask;
    hit      = slot_vld && en && (x == last_q[slot_ch]);
    acc_vld  = hit && (x != (held_q[slot_ch] & mask));
    acc_ch   = slot_ch;
    acc_prim = x;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) begin
        last_q[i] <= '1;
        held_q[i] <= '1;
      end
      twice_q <= '0;
    end else if (slot_vld && en) begin
      if (hit) begin
        twice_q[slot_ch] <= 1'b1;
        if (acc_vld) held_q[slot_ch] <= x;
      end else begin
        last_q[slot_ch]  <= x;
        twice_q[slot_ch] <= 1'b0;
      end
    end
  end

  assign look_prim  = last_q[look_ch];
  assign look_twice = twice_q[look_ch];
endmodule

// File: rtl/ci_evt_fifo.sv
module ci_evt_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned W     = 10,
  localparam int unsigned AW   = $clog2(DEPTH)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         nonempty
);
  logic [W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [AW:0]   cnt;
  logic do_push, do_pop;

  assign do_push  = push && (cnt != (AW+1)'(DEPTH));
  assign do_pop   = pop && (cnt != '0);
  assign nonempty = (cnt != '0);
  assign dout     = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0; rp <= '0; cnt <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
      cnt <= cnt + (AW+1)'(do_push) - (AW+1)'(do_pop);
    end
  end
endmodule

// File: rtl/ci_tdm_ctrl.sv
module ci_tdm_ctrl
  import ci_pkg::*;
#(
  parameter int unsigned N_CH      = 16,
  parameter int unsigned EVQ_DEPTH = 4,
  localparam int unsigned CH_W     = $clog2(N_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_enable,
  input  logic              cfg_wide,
  input  logic              slot_vld,
  input  logic [CH_W-1:0]   slot_ch,
  input  logic [PW-1:0]     rx_in,
  output logic [PW-1:0]     tx_out,
  input  logic              host_we,
  input  logic              host_re,
  input  logic [1:0]        host_addr,
  input  logic [HOST_W-1:0] host_wdata,
  output logic [HOST_W-1:0] host_rdata,
  output logic              irq
);
  localparam int unsigned EW = CH_W + PW;

  logic [PW-1:0]   mask, src_q, look_prim, acc_prim;
  logic [HOST_W-1:0] dst_q;
  logic [CH_W-1:0] last_tx_q, acc_ch;
  logic [1:0]      sel_cnt;
  logic            cmd_go, look_go, stat_pop, look_twice, acc_vld;
  logic [EW-1:0]   head;

  assign mask     = cfg_wide ? '1 : PW'(6'h0F);
  assign cmd_go   = host_we && (host_addr == A_CMD) && !host_wdata[HOST_W-1];
  assign look_go  = host_we && (host_addr == A_CMD) &&  host_wdata[HOST_W-1];
  assign stat_pop = host_re && (host_addr == A_STAT);

  ci_tx_bank #(.N_CH(N_CH)) u_tx (
    .clk(clk), .rst(rst), .en(cfg_enable), .mask(mask),
    .slot_vld(slot_vld), .slot_ch(slot_ch), .rx_in(rx_in),
    .cmd_go(cmd_go), .cmd_ch(host_wdata[CH_W-1:0]), .cmd_prim(src_q),
    .sel_ch(last_tx_q), .sel_cnt(sel_cnt), .tx_out(tx_out)
  );

  ci_rx_filter #(.N_CH(N_CH)) u_rx (
    .clk(clk), .rst(rst), .en(cfg_enable), .mask(mask),
    .slot_vld(slot_vld), .slot_ch(slot_ch), .rx_in(rx_in),
    .look_ch(src_q[CH_W-1:0]), .look_prim(look_prim), .look_twice(look_twice),
    .acc_vld(acc_vld), .acc_ch(acc_ch), .acc_prim(acc_prim)
  );

  ci_evt_fifo #(.DEPTH(EVQ_DEPTH), .W(EW)) u_evq (
    .clk(clk), .rst(rst), .push(acc_vld), .din({acc_ch, acc_prim}),
    .pop(stat_pop), .dout(head), .nonempty(irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q      <= '0;
      dst_q      <= '0;
      last_tx_q  <= '0;
      host_rdata <= '0;
    end else begin
      if (host_we && host_addr == A_SRC) src_q <= host_wdata[PW-1:0];
      if (cmd_go)  last_tx_q <= host_wdata[CH_W-1:0];
      if (look_go) dst_q <= {1'b0, look_twice, look_prim};
      if (host_re) begin
        case (host_addr)
          A_SRC:   host_rdata <= {sel_cnt, src_q};
          A_CMD:   host_rdata <= dst_q;
          A_STAT:  host_rdata <= irq ? {1'b1, {(HOST_W-1-CH_W){1'b0}}, head[EW-1:PW]} : '0;
          default: host_rdata <= {{(HOST_W-PW){1'b0}}, head[PW-1:0]};
        endcase
      end
    end
  end
endmodule

// File: rtl/ci_tdm_ctrl_chk.sv
module ci_tdm_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       cfg_enable,
  input logic       cfg_wide,
  input logic       slot_vld,
  input logic [5:0] rx_in,
  input logic [5:0] tx_out,
  input logic       host_re,
  input logic [1:0] host_addr,
  input logic [7:0] host_rdata,
  input logic       irq,
  input logic       acc_vld
);
  p_passthru_r9: assert property (@(posedge clk) disable iff (rst)
    slot_vld && !cfg_enable |=> tx_out == $past(rx_in));

  p_no_event_off_r9: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |-> !acc_vld);

  p_zero_fill_r4: assert property (@(posedge clk) disable iff (rst)
    slot_vld && cfg_enable && !cfg_wide |=> tx_out[5:4] == 2'b00);

  p_cnt_code_r3: assert property (@(posedge clk) disable iff (rst)
    host_re && host_addr == 2'd0 |=> host_rdata[7:6] != 2'b11);

  p_accept_irq_r6: assert property (@(posedge clk) disable iff (rst)
    acc_vld |=> irq);

  p_empty_stat_r6: assert property (@(posedge clk) disable iff (rst)
    host_re && host_addr == 2'd2 && !irq |=> host_rdata == 8'h00);
endmodule

bind ci_tdm_ctrl ci_tdm_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_wide(cfg_wide),
  .slot_vld(slot_vld), .rx_in(rx_in), .tx_out(tx_out), .host_re(host_re),
  .host_addr(host_addr), .host_rdata(host_rdata), .irq(irq), .acc_vld(acc_vld)
);

// File: tb/ci_tdm_ctrl_bench.sv
`timescale 1ns/1ps
module ci_tdm_ctrl_bench;
  logic clk = 1'b0, rst = 1'b1;
  logic cfg_enable = 1'b1, cfg_wide = 1'b1;
  logic slot_vld = 1'b0;
  logic [3:0] slot_ch = '0;
  logic [5:0] rx_in = '0, tx_out;
  logic host_we = 1'b0, host_re = 1'b0;
  logic [1:0] host_addr = '0;
  logic [7:0] host_wdata = '0, host_rdata;
  logic irq;
  int checks = 0, fails = 0;
  logic [7:0] rd;

  always #4 clk = ~clk;

  ci_tdm_ctrl u_ci_tdm_ctrl (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_wide(cfg_wide),
    .slot_vld(slot_vld), .slot_ch(slot_ch), .rx_in(rx_in), .tx_out(tx_out),
    .host_we(host_we), .host_re(host_re), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic slot(input logic [3:0] ch, input logic [5:0] d);
    @(negedge clk); slot_vld = 1'b1; slot_ch = ch; rx_in = d;
    @(negedge clk); slot_vld = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
  endtask

  task automatic rdreg(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_re = 1'b1; host_addr = a;
    @(negedge clk); host_re = 1'b0; d = host_rdata;
  endtask

  task automatic t_reset;
    check("R1 tx_out", {2'b0, tx_out}, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);
    check("R1 rdata", host_rdata, 8'h00);
    rdreg(2'd2, rd); check("R6 empty status", rd, 8'h00);
    slot(4'd4, 6'h3F); check("R1 default all-ones code", {2'b0, tx_out}, 8'h3F);
  endtask

  task automatic t_tx;
    wr(2'd0, 8'h2A); wr(2'd1, 8'h03);
    rdreg(2'd0, rd); check("R3 count none", rd, 8'h2A);
    slot(4'd3, 6'h3F); check("R2 code sent", {2'b0, tx_out}, 8'h2A);
    rdreg(2'd0, rd); check("R3 count once", rd, 8'h6A);
    slot(4'd3, 6'h3F); check("R2 code repeated", {2'b0, tx_out}, 8'h2A);
    rdreg(2'd0, rd); check("R3 count twice", rd, 8'hAA);
    slot(4'd3, 6'h3F);
    rdreg(2'd0, rd); check("R3 count saturates", rd, 8'hAA);
  endtask

  task automatic t_width;
    cfg_wide = 1'b0;
    wr(2'd0, 8'h3A); wr(2'd1, 8'h05);
    slot(4'd5, 6'h3F); check("R4 tx zero fill", {2'b0, tx_out}, 8'h0A);
    slot(4'd9, 6'h35); slot(4'd9, 6'h35);
    check("R4 narrow accept irq", {7'b0, irq}, 8'h01);
    rdreg(2'd3, rd); check("R4 narrow aux code", rd, 8'h05);
    rdreg(2'd2, rd); check("R6 status ch9", rd, 8'h89);
    cfg_wide = 1'b1;
  endtask

  task automatic t_rx;
    slot(4'd7, 6'h15); check("R5 single copy no irq", {7'b0, irq}, 8'h00);
    slot(4'd2, 6'h3F);
    slot(4'd7, 6'h15); check("R5 pair accepted", {7'b0, irq}, 8'h01);
    rdreg(2'd3, rd); check("R6 aux code", rd, 8'h15);
    rdreg(2'd2, rd); check("R6 status ch7", rd, 8'h87);
    check("R6 irq cleared", {7'b0, irq}, 8'h00);
    slot(4'd7, 6'h15); check("R5 repeat of accepted ignored", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'h07); wr(2'd1, 8'h80);
    rdreg(2'd1, rd); check("R8 lookup twice", rd, 8'h55);
    slot(4'd7, 6'h16);
    wr(2'd1, 8'h80);
    rdreg(2'd1, rd); check("R8 lookup once", rd, 8'h16);
  endtask

  task automatic t_fifo;
    for (int c = 10; c < 15; c++) begin
      slot(4'(c), 6'h01); slot(4'(c), 6'h01);
    end
    check("R7 irq with queue", {7'b0, irq}, 8'h01);
    rdreg(2'd3, rd); check("R7 head aux", rd, 8'h01);
    for (int c = 10; c < 14; c++) begin
      rdreg(2'd2, rd); check("R7 order", rd, 8'h80 | 8'(c));
    end
    rdreg(2'd2, rd); check("R7 overflow dropped", rd, 8'h00);
    check("R6 irq low when empty", {7'b0, irq}, 8'h00);
  endtask

  task automatic t_disable;
    cfg_enable = 1'b0;
    slot(4'd5, 6'h2C); check("R9 pass-through", {2'b0, tx_out}, 8'h2C);
    slot(4'd7, 6'h2C); slot(4'd7, 6'h2C);
    check("R9 no event", {7'b0, irq}, 8'h00);
    rdreg(2'd0, rd); check("R9 count frozen", rd, 8'h47);
    wr(2'd1, 8'h80);
    rdreg(2'd1, rd); check("R9 rx memory untouched", rd, 8'h16);
    cfg_enable = 1'b1;
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_tx();
    t_width();
    t_rx();
    t_fifo();
    t_disable();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule